// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block is a clocked sequencer that sits between a simple host request port and an external asynchronous static RAM of 64K 16-bit words. The host presents an address, write data, a per-byte mask and a direction flag with a valid strobe. The controller turns that into a timed pattern on the memory's active-low select, output-enable, write-enable and per-byte enable pins. It drives the data bus one lane at a time through separate output and output-enable vectors, and returns read data with a one-clock completion pulse.

All wait lengths come from nanosecond parameters divided by the clock period and rounded up. The read access, the write pulse and the bus turnaround therefore follow the memory's speed grade without editing the logic. When output enable is left low through a write, the write pulse is lengthened so that it covers both the memory's output turn-off and the data setup time. A change of transfer direction adds a short all-idle gap so that the controller and the memory never drive the bus at the same moment.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, memCsN, memOeN and memWeN are 1, memBeN is all ones, memDqOe is all zeros, done is 0 and reqReady is 1.
- R2: A read with a nonzero mask holds memCsN=0, memOeN=0 and memWeN=1 for RD_CYC cycles, where RD_CYC = max(ceil(T_ACCESS_PS/CLK_PERIOD_PS), ceil(T_CYCLE_PS/CLK_PERIOD_PS)). During those cycles memBeN equals the inverted mask. Mask bit 0 selects byte 7:0 and mask bit 1 selects byte 15:8. rdData then holds the bus value on the enabled lanes and zero on the other lanes, and it is valid in the cycle where done is 1.
- R3: A write with a nonzero mask holds memCsN=0, memWeN=0 and memBeN equal to the inverted mask. From the fall of memWeN until one cycle after its rise, memDqOut carries the write data and memDqOe is 1 exactly on the masked lanes. memDqOe is zero again when done is 1.
- R4: The write-enable low time is WP_CYC cycles. With WR_OE_LOW=1, memOeN stays 0 through the write and WP_CYC = max(ceil((T_OFF_PS+T_DW_PS)/CLK_PERIOD_PS), ceil(T_CYCLE_PS/CLK_PERIOD_PS)-1, 1). With WR_OE_LOW=0, memOeN stays 1 and the first term becomes ceil(T_WP_PS/CLK_PERIOD_PS).
- R5: A request with mask 0 causes no strobe activity: every memory control pin stays inactive. done pulses on the clock after acceptance, and rdData keeps its previous value.
- R6: When a request reverses the direction of the previous nonzero-mask request, TURN_CYC = max(ceil(T_OFF_PS/CLK_PERIOD_PS),1) extra cycles with all strobes high precede the access. No gap is added when the direction is the same.
- R7: done is high for exactly one clock per request. reqReady is 1 only while the controller is idle and done is 0.
- R8: While memCsN is 0, memAddr does not change. While memCsN is 1, memOeN, memWeN and every memBeN bit are 1.
- R9: The controller never drives a lane while memOeN is 0 and memWeN is 1.
- R10: A write with a one-lane mask leaves the other byte of the stored word unchanged, so a following full-mask read returns the merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller idle, request accepted on valid |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqMask | input | DATA_W/8 | Byte mask, bit 0 = low byte |
| rdData | output | DATA_W | Captured read data |
| done | output | 1 | One-clock completion pulse |
| memAddr | output | ADDR_W | Memory address |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memBeN | output | DATA_W/8 | Byte enables, active low |
| memDqOut | output | DATA_W | Data driven toward memory |
| memDqOe | output | DATA_W/8 | Per-lane drive enable |
| memDqIn | input | DATA_W | Data bus as seen from memory |

## Verification
The bench runs full-word writes and reads, and single-lane reads of each byte. These show whether the byte-enable polarity and the lane order are correct and whether disabled lanes are zeroed. Single-lane writes followed by full reads catch a controller that strobes both lanes or drives the wrong one. Back-to-back pairs in the same direction and in opposite directions separate the turnaround gap from the plain idle gap. Zero-mask requests of both kinds, and accesses at the lowest and highest addresses, confirm that the pins stay quiet and that the address is carried in full.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WRITE,
    ST_WREC
  } lane_state_e;

  // strobes handed from control to datapath, all pin-level polarity
  typedef struct packed {
    logic csN;
    logic oeN;
    logic weN;
    logic laneSel;  // apply latched byte mask to the enables
    logic drive;    // drive the masked lanes onto the bus
  } strobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int RD_CYC    = 1,
  parameter int WP_CYC    = 1,
  parameter int TURN_CYC  = 1,
  parameter bit WR_OE_LOW = 1'b1,
  parameter int LANES     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqMask,
  output logic             reqReady,
  output logic             loadReq,
  output logic             captureRd,
  output logic             done,
  output strobe_t          nextStb
);

  localparam int CNT_MAX = maxOf(maxOf(RD_CYC, WP_CYC), TURN_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  lane_state_e       state, stateNext;
  logic [CNT_W-1:0]  cnt, cntNext;
  logic              wrQ, wrNext;
  logic              lastValid, lastValidNext;
  logic              lastWr, lastWrNext;
  logic              doneNext;
  logic              accept;
  logic              maskAny;

  assign reqReady = (state == ST_IDLE) && !done;
  assign accept   = reqValid && reqReady;
  assign maskAny  = |reqMask;
  assign loadReq  = accept && maskAny;

  always_comb begin
    stateNext     = state;
    cntNext       = cnt;
    wrNext        = wrQ;
    lastValidNext = lastValid;
    lastWrNext    = lastWr;
    doneNext      = 1'b0;
    captureRd     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          if (!maskAny) begin
            doneNext = 1'b1;
          end else begin
            wrNext        = reqWrite;
            cntNext       = '0;
            lastValidNext = 1'b1;
            lastWrNext    = reqWrite;
            if (lastValid && (lastWr != reqWrite)) stateNext = ST_TURN;
            else if (reqWrite)                     stateNext = ST_WRITE;
            else                                   stateNext = ST_READ;
          end
        end
      end
      ST_TURN: begin
        if (cnt == CNT_W'(TURN_CYC - 1)) begin
          cntNext   = '0;
          stateNext = wrQ ? ST_WRITE : ST_READ;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_READ: begin
        if (cnt == CNT_W'(RD_CYC - 1)) begin
          stateNext = ST_IDLE;
          captureRd = 1'b1;
          doneNext  = 1'b1;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_WRITE: begin
        if (cnt == CNT_W'(WP_CYC - 1)) begin
          cntNext   = '0;
          stateNext = ST_WREC;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_WREC: begin
        stateNext = ST_IDLE;
        doneNext  = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // strobes follow the next state so the datapath flops line up with it
  always_comb begin
    nextStb.csN     = !((stateNext == ST_READ) || (stateNext == ST_WRITE));
    nextStb.oeN     = !((stateNext == ST_READ) || ((stateNext == ST_WRITE) && WR_OE_LOW));
    nextStb.weN     = !(stateNext == ST_WRITE);
    nextStb.laneSel = (stateNext == ST_READ) || (stateNext == ST_WRITE);
    nextStb.drive   = (stateNext == ST_WRITE) || (stateNext == ST_WREC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      wrQ       <= 1'b0;
      lastValid <= 1'b0;
      lastWr    <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= stateNext;
      cnt       <= cntNext;
      wrQ       <= wrNext;
      lastValid <= lastValidNext;
      lastWr    <= lastWrNext;
      done      <= doneNext;
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_in_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (state == ST_IDLE));

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int WP_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           nextStb,
  input  logic              loadReq,
  input  logic              captureRd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memBeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic [LANES-1:0]  memDqOe,
  output logic [DATA_W-1:0] rdData
);

  localparam strobe_t STB_IDLE = '{csN: 1'b1, oeN: 1'b1, weN: 1'b1, laneSel: 1'b0, drive: 1'b0};
  localparam int      WR_W     = $clog2(WP_CYC + 2);

  strobe_t           stbQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  laneEnQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stbQ    <= STB_IDLE;
      addrQ   <= '0;
      wdataQ  <= '0;
      laneEnQ <= '0;
    end else begin
      stbQ <= nextStb;
      if (loadReq) begin
        addrQ   <= reqAddr;
        wdataQ  <= reqWdata;
        laneEnQ <= reqMask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (captureRd) begin
      for (int l = 0; l < LANES; l++) begin
        rdQ[l*8 +: 8] <= laneEnQ[l] ? memDqIn[l*8 +: 8] : 8'h00;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign memDqOe[g] = stbQ.drive & laneEnQ[g];
    assign memBeN[g]  = !(stbQ.laneSel & laneEnQ[g]);
  end

  assign memAddr  = addrQ;
  assign memCsN   = stbQ.csN;
  assign memOeN   = stbQ.oeN;
  assign memWeN   = stbQ.weN;
  assign memDqOut = wdataQ;
  assign rdData   = rdQ;

  // write-enable low run length, saturating
  logic [WR_W-1:0] weRun;
  always_ff @(posedge clk) begin
    if (!rstN)                           weRun <= '0;
    else if (memWeN)                     weRun <= '0;
    else if (weRun != {WR_W{1'b1}})      weRun <= weRun + 1'b1;
  end

  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weRun >= WR_W'(WP_CYC)));

  assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    memCsN |-> (memWeN && memOeN && (memBeN == {LANES{1'b1}})));

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));

  assert_no_drive_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN && memWeN) |-> (memDqOe == '0));

  assert_drive_lanes_R3: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memDqOe == ~memBeN));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_ACCESS_PS   = 12000,
  parameter int T_CYCLE_PS    = 12000,
  parameter int T_WP_PS       = 9000,
  parameter int T_OFF_PS      = 6000,
  parameter int T_DW_PS       = 7000,
  parameter bit WR_OE_LOW     = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqMask,
  output logic [DATA_W-1:0]     rdData,
  output logic                  done,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memCsN,
  output logic                  memOeN,
  output logic                  memWeN,
  output logic [DATA_W/8-1:0]   memBeN,
  output logic [DATA_W-1:0]     memDqOut,
  output logic [DATA_W/8-1:0]   memDqOe,
  input  logic [DATA_W-1:0]     memDqIn
);

  localparam int LANES    = DATA_W / 8;
  localparam int CYC_MIN  = ceilDiv(T_CYCLE_PS, CLK_PERIOD_PS);
  localparam int RD_CYC   = maxOf(ceilDiv(T_ACCESS_PS, CLK_PERIOD_PS), maxOf(CYC_MIN, 1));
  localparam int WP_RAW   = WR_OE_LOW ? ceilDiv(T_OFF_PS + T_DW_PS, CLK_PERIOD_PS)
                                      : ceilDiv(T_WP_PS, CLK_PERIOD_PS);
  localparam int WP_CYC   = maxOf(maxOf(WP_RAW, CYC_MIN - 1), 1);
  localparam int TURN_CYC = maxOf(ceilDiv(T_OFF_PS, CLK_PERIOD_PS), 1);

  strobe_t nextStb;
  logic    loadReq;
  logic    captureRd;

  sram_lane_fsm #(
    .RD_CYC   (RD_CYC),
    .WP_CYC   (WP_CYC),
    .TURN_CYC (TURN_CYC),
    .WR_OE_LOW(WR_OE_LOW),
    .LANES    (LANES)
  ) u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqMask  (reqMask),
    .reqReady (reqReady),
    .loadReq  (loadReq),
    .captureRd(captureRd),
    .done     (done),
    .nextStb  (nextStb)
  );

  sram_lane_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES),
    .WP_CYC(WP_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .nextStb  (nextStb),
    .loadReq  (loadReq),
    .captureRd(captureRd),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqMask  (reqMask),
    .memDqIn  (memDqIn),
    .memAddr  (memAddr),
    .memCsN   (memCsN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memBeN   (memBeN),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .rdData   (rdData)
  );

endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  // expected wait lengths for the bench configuration below
  localparam int EXP_RD   = 2;  // max(ceil(35/20), ceil(35/20))
  localparam int EXP_WP   = 2;  // max(ceil((16+10)/20), ceil(35/20)-1, 1)
  localparam int EXP_TURN = 1;  // max(ceil(16/20), 1)

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic [15:0] rdData;
  logic        done;
  logic [15:0] memAddr;
  logic        memCsN, memOeN, memWeN;
  logic [1:0]  memBeN;
  logic [15:0] memDqOut;
  logic [1:0]  memDqOe;
  logic [15:0] memDqIn;

  always #10 clk = ~clk;

  sram_lane_ctrl #(
    .CLK_PERIOD_PS(20000),
    .T_ACCESS_PS  (35000),
    .T_CYCLE_PS   (35000),
    .T_WP_PS      (9000),
    .T_OFF_PS     (16000),
    .T_DW_PS      (10000),
    .WR_OE_LOW    (1'b1)
  ) u_sram_lane_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rdData(rdData), .done(done), .memAddr(memAddr), .memCsN(memCsN),
    .memOeN(memOeN), .memWeN(memWeN), .memBeN(memBeN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // behavioural byte-lane memory
  logic [15:0] ram    [0:65535];
  logic [15:0] shadow [0:65535];

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      memDqIn[l*8 +: 8] = (!memCsN && !memOeN && memWeN && !memBeN[l])
                          ? ram[memAddr][l*8 +: 8] : 8'hA5;
    end
  end

  always @(posedge clk) begin
    if (!memCsN && !memWeN) begin
      for (int l = 0; l < 2; l++) begin
        if (!memBeN[l] && memDqOe[l]) ram[memAddr][l*8 +: 8] <= memDqOut[l*8 +: 8];
      end
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct {
    bit          isWr;
    logic [1:0]  mask;
    logic [15:0] addr;
    logic [15:0] data;
    logic [15:0] expRd;
    int          expGap;
  } item_t;

  item_t scb[$];

  // monitor state
  int          csRun = 0;
  int          gapRun = 1000;
  int          bursts = 0;
  int          strobeCycles = 0;
  bit          donePrev = 1'b0;
  bit          bWr, bOeLow, bStableBad, bDriveBad;
  logic [1:0]  bBe;
  logic [15:0] bAddr;
  int          bGap;
  logic [15:0] lastRd = '0;

  task automatic endBurst();
    item_t it;
    int expLen;
    if (scb.size() == 0) begin
      check(1'b0, "R5", 32'(csRun), 0);
      return;
    end
    it = scb[0];
    bursts++;
    expLen = it.isWr ? EXP_WP : EXP_RD;
    check(bWr == it.isWr, "R3", 32'(bWr), 32'(it.isWr));
    check(csRun == expLen, it.isWr ? "R4" : "R2", 32'(csRun), 32'(expLen));
    check(bBe == ~it.mask, it.isWr ? "R3" : "R2", 32'(bBe), 32'(~it.mask));
    check(bAddr == it.addr, "R8", 32'(bAddr), 32'(it.addr));
    check(!bStableBad, "R8", 32'(bStableBad), 0);
    check(!bDriveBad, it.isWr ? "R3" : "R9", 32'(bDriveBad), 0);
    check(bOeLow, it.isWr ? "R4" : "R2", 32'(bOeLow), 1);
    if (it.expGap >= 0) check(bGap == it.expGap, "R6", 32'(bGap), 32'(it.expGap));
    if (it.isWr) check(memDqOe == it.mask, "R3", 32'(memDqOe), 32'(it.mask));
    gapRun = 0;
  endtask

  task automatic finishItem();
    item_t it;
    if (scb.size() == 0) begin
      check(1'b0, "R7", 1, 0);
      return;
    end
    it = scb.pop_front();
    if (it.isWr) check(memDqOe == 2'b00, "R3", 32'(memDqOe), 0);
    if (it.mask == 2'b00) begin
      check(bursts == 0 && strobeCycles == 0, "R5", 32'(strobeCycles), 0);
      check(rdData == lastRd, "R5", 32'(rdData), 32'(lastRd));
    end else begin
      check(bursts == 1, "R7", 32'(bursts), 1);
      if (!it.isWr) check(rdData == it.expRd, "R2", 32'(rdData), 32'(it.expRd));
    end
    lastRd = rdData;
    bursts = 0;
    strobeCycles = 0;
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (done && donePrev) check(1'b0, "R7", 1, 0);
      donePrev = done;
      if (done) check(!reqReady, "R7", 32'(reqReady), 0);
      if (!memCsN || !memWeN || !memOeN || memBeN != 2'b11) strobeCycles++;
      if (!memCsN) begin
        if (csRun == 0) begin
          bWr = !memWeN; bBe = memBeN; bAddr = memAddr; bGap = gapRun;
          bOeLow = 1'b1; bStableBad = 1'b0; bDriveBad = 1'b0;
        end
        csRun++;
        if (memAddr != bAddr || memBeN != bBe || (!memWeN) != bWr) bStableBad = 1'b1;
        if (memOeN) bOeLow = 1'b0;
        if (!memWeN) begin
          if (memDqOe != ~memBeN) bDriveBad = 1'b1;
          if (scb.size() > 0 &&
              (((memDqOut ^ scb[0].data) & {{8{scb[0].mask[1]}}, {8{scb[0].mask[0]}}}) != 16'h0))
            bDriveBad = 1'b1;
        end else if (memDqOe != 2'b00) begin
          bDriveBad = 1'b1;
        end
      end else begin
        if (csRun > 0) endBurst();
        csRun = 0;
        gapRun++;
      end
      if (done) finishItem();
    end
  end

  // driver
  bit hadOp = 1'b0;
  bit prevWr = 1'b0;
  bit skipGap = 1'b0;

  task automatic doOp(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    item_t it;
    it.isWr = wr; it.mask = m; it.addr = a; it.data = d;
    it.expRd = 16'h0000;
    for (int l = 0; l < 2; l++) begin
      if (m[l]) it.expRd[l*8 +: 8] = shadow[a][l*8 +: 8];
    end
    if (m == 2'b00 || !hadOp || skipGap) it.expGap = -1;
    else it.expGap = (prevWr ? 3 : 2) + ((prevWr != wr) ? EXP_TURN : 0);
    if (m != 2'b00) begin
      hadOp = 1'b1; prevWr = wr; skipGap = 1'b0;
      if (wr) begin
        for (int l = 0; l < 2; l++) begin
          if (m[l]) shadow[a][l*8 +: 8] = d[l*8 +: 8];
        end
      end
    end else if (hadOp) begin
      skipGap = 1'b1;
    end
    scb.push_back(it);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  initial begin
    for (int i = 0; i < 65536; i++) begin
      ram[i] = 16'h0000;
      shadow[i] = 16'h0000;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(memCsN && memOeN && memWeN, "R1", {29'd0, memCsN, memOeN, memWeN}, 7);
    check(memBeN == 2'b11, "R1", 32'(memBeN), 3);
    check(memDqOe == 2'b00, "R1", 32'(memDqOe), 0);
    check(!done && reqReady, "R1", {30'd0, done, reqReady}, 1);

    doOp(1'b1, 16'h0010, 16'h1234, 2'b11);
    doOp(1'b0, 16'h0010, 16'h0000, 2'b11);   // R2 full read, R6 turnaround
    doOp(1'b0, 16'h0010, 16'h0000, 2'b01);   // R2 low lane only
    doOp(1'b0, 16'h0010, 16'h0000, 2'b10);   // R2 high lane only
    doOp(1'b1, 16'h0010, 16'hABCD, 2'b01);   // R10 partial write low
    doOp(1'b1, 16'h0010, 16'h5500, 2'b10);   // R10 partial write high
    doOp(1'b0, 16'h0010, 16'h0000, 2'b11);   // R10 merged readback
    doOp(1'b1, 16'h0010, 16'hFFFF, 2'b00);   // R5 zero-mask write
    doOp(1'b0, 16'h0010, 16'h0000, 2'b00);   // R5 zero-mask read
    doOp(1'b0, 16'h0010, 16'h0000, 2'b11);   // R5 word untouched
    doOp(1'b1, 16'hFFFF, 16'hA5C3, 2'b11);
    doOp(1'b1, 16'h0000, 16'h3C5A, 2'b11);
    doOp(1'b0, 16'hFFFF, 16'h0000, 2'b11);
    doOp(1'b0, 16'h0000, 16'h0000, 2'b11);
    for (int i = 0; i < 12; i++) begin
      doOp(i[0], 16'h0100 + 16'(i % 4), 16'(i * 16'h1357 + 16'h0F0F), 2'(i % 3 + 1));
    end
    for (int i = 0; i < 4; i++) begin
      doOp(1'b0, 16'h0100 + 16'(i), 16'h0000, 2'b11);
    end
    repeat (3) @(negedge clk);
    check(scb.size() == 0, "R7", 32'(scb.size()), 0);
    report();
  end

endmodule